// File: doc/BRIEF.md
# FIFO DMA Request Controller

This block drives the DMA request line that moves bytes between the host and a FIFO data port. Software controls it with a DMA enable bit and a service bit. The FIFO reports full and empty flags. A direction input selects the transfer: 0 means host to FIFO, 1 means FIFO to host. A test-mode flag keeps the request open whatever the FIFO flags say. While the DMA acknowledge is low, each host write strobe becomes a FIFO push and each host read strobe becomes a FIFO pop.

The block counts the data cycles of each burst. The request is withdrawn once more than a set number of consecutive cycles has been acknowledged. That number is 32 by default. The count returns to zero whenever the acknowledge goes high.

The block stops the request for three reasons, and each one restarts in its own way:

- A full or empty stop ends by itself when the flag clears.
- A burst-limit stop ends by itself once the acknowledge has gone high.
- A stop caused by the service bit (for example, a terminal-count event setting it) ends only when software clears the bit.

No data passes through this block. All of its pins are plain control and status lines, with no valid/ready handshake.

Top module: `dma_req_ctrl`

## Requirements
- R1: While rst_n is low, dma_req, fifo_push and fifo_pop are 0, and the burst count is zero.
- R2: dma_req is a register. It takes the value of the request condition sampled at the previous rising clock edge.
- R3: The request condition is true only when all of the following hold:
  - dma_en is 1;
  - svc_bit is 0;
  - the burst limit has not been exceeded;
  - one of these is true: dir=0 with fifo_full=0, or dir=1 with fifo_empty=0, or test_mode=1.
- R4: With dir=0 and test_mode=0, fifo_full=1 removes the request. The request returns without software action once fifo_full is 0 again.
- R5: With dir=1 and test_mode=0, fifo_empty=1 removes the request. The request returns without software action once fifo_empty is 0 again.
- R6: With test_mode=1, the request ignores fifo_full and fifo_empty.
- R7: svc_bit=1 or dma_en=0 removes the request. After svc_bit is set, the request returns only when svc_bit is written back to 0.
- R8: fifo_push equals host_wr AND (dack_n=0), and fifo_pop equals host_rd AND (dack_n=0). Both are combinational. A strobe that arrives while dack_n=1 moves no data.
- R9: Each clock cycle in which fifo_push or fifo_pop is 1 adds one to the burst count. The count saturates at BURST_MAX+1. When the count exceeds BURST_MAX (default 32), dma_req is 0 from the next edge onward. After exactly BURST_MAX cycles, the request stays up.
- R10: A clock edge that sees dack_n=1 clears the burst count. After that, the request resumes with no software action.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dma_en | input | 1 | DMA enable control bit |
| svc_bit | input | 1 | Service bit; 1 masks the request |
| dir | input | 1 | 0: host to FIFO, 1: FIFO to host |
| fifo_full | input | 1 | FIFO full flag |
| fifo_empty | input | 1 | FIFO empty flag |
| test_mode | input | 1 | Request regardless of FIFO flags |
| dack_n | input | 1 | DMA acknowledge, active low |
| host_wr | input | 1 | Host write strobe, one cycle per data cycle |
| host_rd | input | 1 | Host read strobe, one cycle per data cycle |
| dma_req | output | 1 | Registered DMA request |
| fifo_push | output | 1 | Write one byte into the FIFO |
| fifo_pop | output | 1 | Read one byte from the FIFO |

## Verification
The assertions assume the following about the inputs:

- host_wr and host_rd are never high in the same cycle.
- Each strobe lasts one clock cycle per data cycle.
- Every input changes only once per clock period, away from the rising edge.

The stimulus drives inputs shortly after each rising edge. It raises at most one strobe at a time and clears each strobe after a single cycle, so the count advances exactly once per transfer. The stimulus never holds dack_n low across reset.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;
  localparam int unsigned DEF_BURST_MAX = 32;

  function automatic logic flow_open(input logic dir, input logic full,
                                     input logic empty, input logic tmode);
    return tmode | (~dir & ~full) | (dir & ~empty);
  endfunction
endpackage

// File: rtl/dma_burst_cnt.sv
module dma_burst_cnt #(
  parameter int unsigned BURST_MAX = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dack_n,
  input  logic xfer,
  output logic over
);
  localparam int unsigned CW  = $clog2(BURST_MAX + 2);
  localparam logic [CW-1:0] SAT = CW'(BURST_MAX + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (dack_n)       cnt <= '0;
    else if (xfer && cnt != SAT) cnt <= cnt + 1'b1;
  end

  assign over = (cnt > CW'(BURST_MAX));

  AST_CNT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dack_n) |-> cnt == '0); // R10
  AST_CNT_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt) |-> (cnt == '0 || cnt == $past(cnt) + 1'b1)); // R9
  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= SAT); // R9
endmodule

// File: rtl/dma_req_gen.sv
module dma_req_gen
  import dma_req_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic dma_en,
  input  logic svc_bit,
  input  logic dir,
  input  logic fifo_full,
  input  logic fifo_empty,
  input  logic test_mode,
  input  logic over,
  output logic dma_req
);
  logic want;

  always_comb
    want = dma_en & ~svc_bit & ~over & flow_open(dir, fifo_full, fifo_empty, test_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dma_req <= 1'b0;
    else        dma_req <= want;
  end

  AST_BURST_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(over) |-> !dma_req); // R9
  AST_MASK_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(svc_bit || !dma_en) |-> !dma_req); // R7
  AST_FULL_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!dir && fifo_full && !test_mode) |-> !dma_req); // R4
  AST_EMPTY_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dir && fifo_empty && !test_mode) |-> !dma_req); // R5
endmodule

// File: rtl/dma_req_ctrl.sv
module dma_req_ctrl
  import dma_req_pkg::*;
#(
  parameter int unsigned BURST_MAX = DEF_BURST_MAX
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dma_en,
  input  logic svc_bit,
  input  logic dir,
  input  logic fifo_full,
  input  logic fifo_empty,
  input  logic test_mode,
  input  logic dack_n,
  input  logic host_wr,
  input  logic host_rd,
  output logic dma_req,
  output logic fifo_push,
  output logic fifo_pop
);
  logic over;

  assign fifo_push = host_wr & ~dack_n & rst_n;
  assign fifo_pop  = host_rd & ~dack_n & rst_n;

  dma_burst_cnt #(.BURST_MAX(BURST_MAX)) u_cnt (
    .clk(clk), .rst_n(rst_n), .dack_n(dack_n),
    .xfer(fifo_push | fifo_pop), .over(over)
  );

  dma_req_gen u_gen (
    .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .svc_bit(svc_bit), .dir(dir),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .test_mode(test_mode),
    .over(over), .dma_req(dma_req)
  );

  AST_NO_MOVE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    dack_n |-> !(fifo_push || fifo_pop)); // R8
endmodule

// File: tb/dma_req_ctrl_tb.sv
module dma_req_ctrl_tb;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic dma_en = 0, svc_bit = 0, dir = 0, fifo_full = 0, fifo_empty = 0;
  logic test_mode = 0, dack_n = 1, host_wr = 0, host_rd = 0;
  logic dma_req, fifo_push, fifo_pop;
  int n_chk = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  dma_req_ctrl u_dut (.*);

  task automatic check(input logic got, input logic exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic strobe(input logic wr);
    host_wr = wr; host_rd = ~wr;
    step();
    host_wr = 0; host_rd = 0;
  endtask

  task automatic t_reset();
    dma_en = 1; host_wr = 1; dack_n = 0; #1;
    check(dma_req, 0, "R1 req in reset");
    check(fifo_push, 0, "R1 push in reset");
    host_wr = 0; dack_n = 1; dma_en = 0;
    step(); rst_n = 1; step();
  endtask

  task automatic t_basic();
    dir = 0; dma_en = 1; #1;
    check(dma_req, 0, "R2 not yet registered");
    step(); check(dma_req, 1, "R3 dir0 request");
    dma_en = 0; step(); check(dma_req, 0, "R7 enable off");
    dma_en = 1; step();
  endtask

  task automatic t_full();
    fifo_full = 1; step(); check(dma_req, 0, "R4 full stop");
    fifo_full = 0; step(); check(dma_req, 1, "R4 auto resume");
  endtask

  task automatic t_empty();
    dir = 1; fifo_empty = 1; step(); check(dma_req, 0, "R5 empty stop");
    fifo_full = 1; fifo_empty = 0; step(); check(dma_req, 1, "R5 resume, full ignored dir1");
    fifo_full = 0; dir = 0;
  endtask

  task automatic t_test();
    test_mode = 1; fifo_full = 1; fifo_empty = 1; step();
    check(dma_req, 1, "R6 test mode ignores flags");
    test_mode = 0; step(); check(dma_req, 0, "R6 flags again after test mode");
    fifo_full = 0; fifo_empty = 0; step();
  endtask

  task automatic t_svc();
    svc_bit = 1; step(); check(dma_req, 0, "R7 svc stop");
    step(3); check(dma_req, 0, "R7 stays stopped");
    svc_bit = 0; step(); check(dma_req, 1, "R7 resume after clear");
  endtask

  task automatic t_strobes();
    dack_n = 1; host_wr = 1; #1; check(fifo_push, 0, "R8 no push without ack");
    host_wr = 0; host_rd = 1; #1; check(fifo_pop, 0, "R8 no pop without ack");
    host_rd = 0; dack_n = 0; host_wr = 1; #1; check(fifo_push, 1, "R8 push with ack");
    host_wr = 0; host_rd = 1; #1; check(fifo_pop, 1, "R8 pop with ack");
    host_rd = 0; dack_n = 1; step();
  endtask

  task automatic t_burst();
    dack_n = 0; step();
    for (int i = 0; i < 32; i++) strobe(i[0]);
    step(); check(dma_req, 1, "R9 32 cycles still requesting");
    strobe(1); check(dma_req, 1, "R9 one edge of latency");
    step(); check(dma_req, 0, "R9 burst limit stop");
    step(2); check(dma_req, 0, "R9 held while ack low");
    dack_n = 1; step(); step(); check(dma_req, 1, "R10 resume after ack high");
    dack_n = 0; for (int i = 0; i < 20; i++) strobe(0);
    dack_n = 1; step(); dack_n = 0;
    for (int i = 0; i < 20; i++) strobe(1);
    step(); check(dma_req, 1, "R10 count cleared between bursts");
    dack_n = 1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    step();
    t_reset(); t_basic(); t_full(); t_empty(); t_test();
    t_svc(); t_strobes(); t_burst();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule